// File: doc/BRIEF.md
# Floppy Drive Power and Ready Sequencer

This block brings a floppy drive up and down around the host's suspend state. Whenever the device is awake, it holds an active-low enable for an external power switch. When a motor request arrives, it selects the drive first. It then turns the motor on and permits head steps only once the drive's active-low ready line has been seen. A configuration bit picks one of two ready policies. In the first, the motor is withheld until ready. In the second, the motor starts at once and only the first step waits for ready.

A second configuration bit tells the block whether the drive refreshes its disk-change line only while the spindle turns. The block combines that bit with the motor state into a single flag that says whether a disk-change read can be trusted.

Entering suspend takes the drive down in a fixed order: motor, then select, then power. If the drive never reports ready, a watchdog abandons the attempt. It raises an error and releases both select and motor.

Top module: `drive_pwr_seq`

## Requirements
- R1: While rst_ni is low, pwr_en_no, drv_sel_no and motor_on_no are released high at once (open-drain outputs released), and step_ok_o, step_go_o, chg_valid_o and rdy_tmo_o are 0.
- R2: While suspend_i is high and the block is idle, pwr_en_no stays high. One clock edge after suspend_i is sampled low, pwr_en_no goes low and stays low until a suspend shutdown completes.
- R3: With power on and no error, a high motor_req_i drives drv_sel_no low after one edge. Select is never active while power is off.
- R4: With cfg_rdy_after_i = 0, motor_on_no stays high while drv_sel_no is low and drv_rdy_ni has not yet been sampled low. After drv_rdy_ni is sampled low, motor_on_no falls two edges later. The motor is never on without select.
- R5: With cfg_rdy_after_i = 1, motor_on_no falls two edges after the motor request, without waiting for ready. step_ok_o stays 0 until drv_rdy_ni is sampled low, and it rises on that same edge.
- R6: A ready indication is remembered from the first time it is seen until the next power-off. A later motor request in the same power period then reaches motor-on two edges after the request, even if drv_rdy_ni is high.
- R7: chg_valid_o is 1 when power is on and either cfg_chg_motor_i = 0 or the motor is on. Otherwise it is 0, including when cfg_chg_motor_i = 1 and the motor is off.
- R8: When suspend_i is sampled high with the motor on, motor_on_no rises on the first edge, drv_sel_no rises on the second and pwr_en_no rises on the third. Suspend takes priority over a motor request that drops in the same cycle.
- R9: If ready is still awaited after 2^TMO_W edges of waiting, rdy_tmo_o rises and both select and motor are released. The error clears one edge after motor_req_i is sampled low.
- R10: step_go_o equals step_req_i AND step_ok_o, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| suspend_i | input | 1 | Device suspended |
| motor_req_i | input | 1 | Request to spin the drive |
| step_req_i | input | 1 | Request to issue a head step |
| drv_rdy_ni | input | 1 | Drive ready, active low |
| cfg_rdy_after_i | input | 1 | 0: hold motor until ready; 1: motor at once, hold step until ready |
| cfg_chg_motor_i | input | 1 | 1: disk-change line valid only with motor on |
| pwr_en_no | output | 1 | Drive power switch enable, active low |
| drv_sel_no | output | 1 | Drive select, active low |
| motor_on_no | output | 1 | Motor on, active low |
| step_ok_o | output | 1 | Stepping permitted |
| step_go_o | output | 1 | Step request granted this cycle |
| chg_valid_o | output | 1 | Disk-change status may be trusted |
| rdy_tmo_o | output | 1 | Ready timeout error |

## Verification
Two events can coincide: a suspend and the withdrawal of the motor request, arriving in the same cycle while the motor runs. The bench raises suspend_i and lowers motor_req_i together. It then checks that select and power are still asserted one edge later. This shows the shutdown order was taken rather than the plain release path, which would drop select together with the motor. A second coincidence is ready arriving while the waiting counter runs. The bench releases ready well inside the window and checks that no error appears.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PWR    = 3'd1,
    ST_SEL    = 3'd2,
    ST_RUN    = 3'd3,
    ST_DN_MTR = 3'd4,
    ST_DN_SEL = 3'd5
  } seq_st_e;

endpackage

// File: rtl/drv_rdy_timer.sv
module drv_rdy_timer #(
  parameter int unsigned TMO_W = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel_act_i,
  input  logic wait_i,
  input  logic rdy_ni,
  output logic rdy_seen_o,
  output logic tmo_o
);

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wait_i) cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  // ready is latched once per power period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_q <= 1'b0;
    else if (clr_i)                  seen_q <= 1'b0;
    else if (sel_act_i && !rdy_ni)   seen_q <= 1'b1;
  end

  assign rdy_seen_o = seen_q;
  assign tmo_o      = wait_i && rdy_ni && (cnt_q == CNT_MAX);

  assert_seen_needs_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen_q) |-> $past(sel_act_i) && !$past(rdy_ni));

  assert_seen_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !seen_q);

endmodule

// File: rtl/drv_seq_fsm.sv
module drv_seq_fsm
  import drv_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    suspend_i,
  input  logic    motor_req_i,
  input  logic    cfg_rdy_after_i,
  input  logic    rdy_seen_i,
  input  logic    tmo_i,
  output seq_st_e st_o,
  output logic    err_o,
  output logic    wait_o,
  output logic    sel_act_o,
  output logic    clr_o
);

  seq_st_e st_q, st_d;
  logic    err_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (!suspend_i) st_d = ST_PWR;
      ST_PWR: begin
        if (suspend_i)                   st_d = ST_OFF;
        else if (motor_req_i && !err_q)  st_d = ST_SEL;
      end
      ST_SEL: begin
        if (suspend_i)                          st_d = ST_DN_SEL;
        else if (!motor_req_i || tmo_i)         st_d = ST_PWR;
        else if (cfg_rdy_after_i || rdy_seen_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (suspend_i)                  st_d = ST_DN_MTR;
        else if (!motor_req_i || tmo_i) st_d = ST_PWR;
      end
      ST_DN_MTR: st_d = ST_DN_SEL;
      ST_DN_SEL: st_d = ST_OFF;
      default:   st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             err_q <= 1'b0;
    else if (st_q == ST_OFF) err_q <= 1'b0;
    else if (tmo_i)          err_q <= 1'b1;
    else if (!motor_req_i)   err_q <= 1'b0;
  end

  assign wait_o    = !rdy_seen_i &&
                     (((st_q == ST_SEL) && !cfg_rdy_after_i) ||
                      ((st_q == ST_RUN) &&  cfg_rdy_after_i));
  assign sel_act_o = (st_q == ST_SEL) || (st_q == ST_RUN);
  assign clr_o     = (st_q == ST_OFF);
  assign st_o      = st_q;
  assign err_o     = err_q;

  assert_pwr_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && !suspend_i) |=> st_q == ST_PWR);

  assert_hold_motor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEL && !cfg_rdy_after_i && !rdy_seen_i) |=> st_q != ST_RUN);

  assert_dn_mtr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && suspend_i) |=> st_q == ST_DN_MTR);

  assert_dn_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DN_MTR |=> st_q == ST_DN_SEL);

  assert_dn_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DN_SEL |=> st_q == ST_OFF);

  assert_tmo_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !suspend_i) |=> err_q && st_q == ST_PWR);

endmodule

// File: rtl/drv_out_decode.sv
module drv_out_decode
  import drv_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  seq_st_e st_i,
  input  logic    rdy_seen_i,
  input  logic    step_req_i,
  input  logic    cfg_chg_motor_i,
  output logic    pwr_en_no,
  output logic    drv_sel_no,
  output logic    motor_on_no,
  output logic    step_ok_o,
  output logic    step_go_o,
  output logic    chg_valid_o
);

  logic pwr_on, sel_on, mtr_on;

  always_comb begin
    pwr_on = 1'b0;
    sel_on = 1'b0;
    mtr_on = 1'b0;
    unique case (st_i)
      ST_OFF:    ;
      ST_PWR:    pwr_on = 1'b1;
      ST_SEL:    begin pwr_on = 1'b1; sel_on = 1'b1; end
      ST_RUN:    begin pwr_on = 1'b1; sel_on = 1'b1; mtr_on = 1'b1; end
      ST_DN_MTR: begin pwr_on = 1'b1; sel_on = 1'b1; end
      ST_DN_SEL: pwr_on = 1'b1;
      default:   ;
    endcase
  end

  assign pwr_en_no   = !pwr_on;
  assign drv_sel_no  = !sel_on;
  assign motor_on_no = !mtr_on;
  assign step_ok_o   = mtr_on && rdy_seen_i;
  assign step_go_o   = step_ok_o && step_req_i;
  assign chg_valid_o = pwr_on && (!cfg_chg_motor_i || mtr_on);

  assert_sel_needs_pwr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_sel_no |-> !pwr_en_no);

  assert_step_needs_rdy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ok_o |-> rdy_seen_i && !motor_on_no);

  assert_chg_motor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_chg_motor_i && motor_on_no) |-> !chg_valid_o);

  assert_step_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_go_o |-> step_req_i);

endmodule

// File: rtl/drive_pwr_seq.sv
module drive_pwr_seq
  import drv_seq_pkg::*;
#(
  parameter int unsigned TMO_W = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic suspend_i,
  input  logic motor_req_i,
  input  logic step_req_i,
  input  logic drv_rdy_ni,
  input  logic cfg_rdy_after_i,
  input  logic cfg_chg_motor_i,
  output logic pwr_en_no,
  output logic drv_sel_no,
  output logic motor_on_no,
  output logic step_ok_o,
  output logic step_go_o,
  output logic chg_valid_o,
  output logic rdy_tmo_o
);

  seq_st_e st;
  logic    rdy_seen, tmo, wait_rdy, sel_act, clr;

  drv_seq_fsm i_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .suspend_i       (suspend_i),
    .motor_req_i     (motor_req_i),
    .cfg_rdy_after_i (cfg_rdy_after_i),
    .rdy_seen_i      (rdy_seen),
    .tmo_i           (tmo),
    .st_o            (st),
    .err_o           (rdy_tmo_o),
    .wait_o          (wait_rdy),
    .sel_act_o       (sel_act),
    .clr_o           (clr)
  );

  drv_rdy_timer #(.TMO_W(TMO_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .sel_act_i  (sel_act),
    .wait_i     (wait_rdy),
    .rdy_ni     (drv_rdy_ni),
    .rdy_seen_o (rdy_seen),
    .tmo_o      (tmo)
  );

  drv_out_decode i_dec (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .st_i            (st),
    .rdy_seen_i      (rdy_seen),
    .step_req_i      (step_req_i),
    .cfg_chg_motor_i (cfg_chg_motor_i),
    .pwr_en_no       (pwr_en_no),
    .drv_sel_no      (drv_sel_no),
    .motor_on_no     (motor_on_no),
    .step_ok_o       (step_ok_o),
    .step_go_o       (step_go_o),
    .chg_valid_o     (chg_valid_o)
  );

  assert_mtr_needs_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !motor_on_no |-> !drv_sel_no);

  assert_err_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_tmo_o |-> drv_sel_no && motor_on_no);

endmodule

// File: tb/test_drive_pwr_seq.sv
module test_drive_pwr_seq;

  localparam int unsigned TMO_W = 4;

  logic clk = 1'b0;
  logic rst_ni, suspend, mreq, step_req, rdy_n, cfg_after, cfg_chg;
  logic pwr_n, sel_n, mtr_n, step_ok, step_go, chg_valid, tmo_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  drive_pwr_seq #(.TMO_W(TMO_W)) i_drive_pwr_seq (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .suspend_i       (suspend),
    .motor_req_i     (mreq),
    .step_req_i      (step_req),
    .drv_rdy_ni      (rdy_n),
    .cfg_rdy_after_i (cfg_after),
    .cfg_chg_motor_i (cfg_chg),
    .pwr_en_no       (pwr_n),
    .drv_sel_no      (sel_n),
    .motor_on_no     (mtr_n),
    .step_ok_o       (step_ok),
    .step_go_o       (step_go),
    .chg_valid_o     (chg_valid),
    .rdy_tmo_o       (tmo_err)
  );

  // {motor_req, chg_needs_motor, step_req, exp motor_on_no, exp chg_valid, exp step_go}
  localparam logic [5:0] TBL [6] = '{
    6'b100_010, 6'b101_011, 6'b111_011,
    6'b011_100, 6'b001_110, 6'b110_010
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; suspend = 1'b1; mreq = 1'b0; step_req = 1'b0;
    rdy_n = 1'b1; cfg_after = 1'b0; cfg_chg = 1'b0;
    #10;
    chk("R1 pwr", pwr_n, 1); chk("R1 sel", sel_n, 1); chk("R1 mtr", mtr_n, 1);
    chk("R1 err", tmo_err, 0); chk("R1 chg", chg_valid, 0); chk("R1 step", step_ok, 0);
    @(posedge clk); #2; rst_ni = 1'b1;

    tick(3); chk("R2 held off", pwr_n, 1);
    suspend = 1'b0;
    tick(1); chk("R2 power on", pwr_n, 0);
    chk("R7 no motor needed", chg_valid, 1);

    // before-motor mode, ready late
    mreq = 1'b1;
    tick(1); chk("R3 select", sel_n, 0); chk("R4 motor held", mtr_n, 1);
    tick(7); chk("R4 still held", mtr_n, 1); chk("R4 sel kept", sel_n, 0);
    chk("R4 no step", step_ok, 0); chk("R9 no err early", tmo_err, 0);
    rdy_n = 1'b0;
    tick(1); chk("R4 one edge", mtr_n, 1);
    tick(1); chk("R4 motor on", mtr_n, 0); chk("R4 step ok", step_ok, 1);
    cfg_chg = 1'b1;
    #1 chk("R7 motor on", chg_valid, 1);

    // ready latched for the power period
    mreq = 1'b0;
    tick(2); chk("R6 released", mtr_n, 1); chk("R3 sel off", sel_n, 1);
    chk("R7 motor off", chg_valid, 0);
    rdy_n = 1'b1; mreq = 1'b1;
    tick(2); chk("R6 fast restart", mtr_n, 0);

    // shutdown order
    suspend = 1'b1;
    tick(1); chk("R8 mtr first", mtr_n, 1); chk("R8 sel kept", sel_n, 0); chk("R8 pwr kept", pwr_n, 0);
    tick(1); chk("R8 sel second", sel_n, 1); chk("R8 pwr kept2", pwr_n, 0);
    tick(1); chk("R8 pwr third", pwr_n, 1); chk("R7 off", chg_valid, 0);

    // after-motor mode
    cfg_after = 1'b1; cfg_chg = 1'b0; step_req = 1'b1; suspend = 1'b0;
    tick(2); chk("R5 sel", sel_n, 0); chk("R5 not yet", mtr_n, 1);
    tick(1); chk("R5 motor at once", mtr_n, 0);
    tick(5); chk("R5 step held", step_ok, 0); chk("R10 no go", step_go, 0);
    rdy_n = 1'b0;
    tick(1); chk("R5 step ok", step_ok, 1); chk("R10 go", step_go, 1);
    step_req = 1'b0;
    #1 chk("R10 no req", step_go, 0);

    foreach (TBL[i]) begin
      mreq = TBL[i][5]; cfg_chg = TBL[i][4]; step_req = TBL[i][3];
      tick(4);
      chk("R7 table mtr", mtr_n, TBL[i][2]);
      chk("R7 table chg", chg_valid, TBL[i][1]);
      chk("R10 table go", step_go, TBL[i][0]);
    end

    // suspend and request drop together: suspend wins
    suspend = 1'b1; mreq = 1'b0; step_req = 1'b0;
    tick(1); chk("R8 coincide sel", sel_n, 0); chk("R8 coincide mtr", mtr_n, 1);
    tick(3); chk("R8 coincide off", pwr_n, 1);

    // timeout
    cfg_after = 1'b0; rdy_n = 1'b1; suspend = 1'b0; mreq = 1'b1;
    tick(12); chk("R9 before tmo", tmo_err, 0); chk("R9 sel waiting", sel_n, 0);
    tick(10); chk("R9 err", tmo_err, 1); chk("R9 sel released", sel_n, 1);
    chk("R9 mtr released", mtr_n, 1);
    mreq = 1'b0;
    tick(1); chk("R9 err cleared", tmo_err, 0);

    // async reset mid-run
    mreq = 1'b1; rdy_n = 1'b0;
    tick(3); chk("R4 tied ready", mtr_n, 0);
    rst_ni = 1'b0;
    #1 chk("R1 async mtr", mtr_n, 1); chk("R1 async sel", sel_n, 1); chk("R1 async pwr", pwr_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule